// File: doc/BRIEF.md
# Segment LCD Clock and Pin-Enable Controller

This block holds the configuration of a segment LCD driver and turns it into three things the waveform logic downstream needs: a divided clock-enable pulse, a code that tells the SEG/COM pads whether to float, drive low or run normally, and the frame-count, duty and display-state fields. The four candidate operating clocks arrive as single-cycle tick strobes that are synchronous to the system clock. A two-bit field picks one of them, and a three-bit field sets a power-of-two prescale.

Software reaches four 16-bit registers through a synchronous byte-addressed port: clock select (0x00), control (0x02), timing (0x04) and display state (0x06). The clock-select register is frozen while the driver is enabled. Disabling the driver stops the prescaler, floats the pads and forces the display state back to idle.

Top module: `lcd_clkctl`

## Requirements
- R1: Clock select bits 1:0 pick the tick that feeds the prescaler (0 internal, 1 low-speed, 2 high-speed, 3 external, i.e. `src_tick_i[code]`); ticks on the other three inputs have no effect on `clk_en_o`.
- R2: Clock select bits 6:4 set the division. Code 0 gives a pulse on every selected tick, and code n from 1 to 6 gives one pulse every 2^(n+3) selected ticks (16 up to 512). A write carrying code 7 leaves the stored divider unchanged but still updates bits 1:0.
- R3: While control bit 0 (enable) is 1, writes to the clock-select register are ignored.
- R4: Control bit 0 is enable and bit 1 is discharge, and both reset to 0. Control bits 15:2 read as 0. While enable is 0, `pin_mode_o` is 2'b00 (Hi-Z).
- R5: The pin code is 2'b00 Hi-Z, 2'b01 drive low or 2'b10 normal. While enabled: display state 0 (idle) gives drive low, display state 1 (off) gives drive low if discharge is 1 and Hi-Z otherwise, and display state 2 or 3 (on) gives normal.
- R6: A write that clears enable while enable is 1 also clears the display-state field (register 0x06, bits 1:0) to 0 in the same cycle.
- R7: Timing register bits 12:8 hold the frame count (reset 0x01) and bits 4:0 hold the duty (reset 0x1F). Both drive `frame_cnt_o` and `duty_o`, and the other bits read as 0.
- R8: Read data appears on `rdata_o` the cycle after `rd_en_i`. A read of an unmapped address returns 0.
- R9: `clk_en_o` is never high in a cycle after one with enable at 0. The prescaler restarts on each enable, so the first pulse follows the N-th selected tick, where N is the division ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick_i | input | 4 | One-cycle tick strobes of the four candidate clock sources |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after the read strobe |
| clk_en_o | output | 1 | Divided operating-clock enable pulse |
| pin_mode_o | output | 2 | SEG/COM pad mode code |
| frame_cnt_o | output | 5 | Frame-count field |
| duty_o | output | 5 | Duty field |
| disp_ctl_o | output | 2 | Display-state field |

## Verification
A wrong prescaler count shows up as a shifted first pulse or a wrong pulse tally within one division period of enabling. That can take up to 512 selected ticks, so the runs at each ratio must cover at least two full periods. Lock, reserved-code and reserved-bit faults show up on the first read-back after the offending write. Pin-mode and clearing faults show on `pin_mode_o` and `disp_ctl_o` one cycle after the control write, so every display and discharge combination is visited with enable both set and cleared.

// File: rtl/lcd_clkctl_pkg.sv
// Shared types and register addresses for the LCD clock/enable controller.
// Assumes byte addressing with 16-bit registers on even addresses.
package lcd_clkctl_pkg;

    typedef enum logic [1:0] {
        PIN_HIZ    = 2'b00,
        PIN_LOW    = 2'b01,
        PIN_NORMAL = 2'b10
    } pin_mode_e;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CLKSEL = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h02;
    localparam logic [ADDR_W-1:0] A_TIMING = 8'h04;
    localparam logic [ADDR_W-1:0] A_DISP   = 8'h06;

    localparam logic [2:0] DIV_RESERVED = 3'd7;

endpackage

// File: rtl/lcd_clkctl_regs.sv
// Register file: clock select, control, timing and display state.
// Clock select is write-locked while enabled. A divider code of 7 is never
// stored. Dropping enable clears the display state. Reads are registered.
module lcd_clkctl_regs
    import lcd_clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        src_o,
    output logic [2:0]        div_o,
    output logic              en_o,
    output logic              dis_o,
    output logic [4:0]        frame_o,
    output logic [4:0]        duty_o,
    output logic [1:0]        disp_o
);

    logic [1:0]        src_q;
    logic [2:0]        div_q;
    logic              en_q;
    logic              dis_q;
    logic [4:0]        frame_q;
    logic [4:0]        duty_q;
    logic [1:0]        disp_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata_i[15:13], wdata_i[7]};

    // Register writes, clock-select lock and display clear on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            div_q   <= '0;
            en_q    <= 1'b0;
            dis_q   <= 1'b0;
            frame_q <= 5'h01;
            duty_q  <= 5'h1f;
            disp_q  <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                A_CLKSEL: begin
                    if (!en_q) begin
                        src_q <= wdata_i[1:0];
                        if (wdata_i[6:4] != DIV_RESERVED)
                            div_q <= wdata_i[6:4];
                    end
                end
                A_CTRL: begin
                    en_q  <= wdata_i[0];
                    dis_q <= wdata_i[1];
                    if (en_q && !wdata_i[0])
                        disp_q <= '0;
                end
                A_TIMING: begin
                    frame_q <= wdata_i[12:8];
                    duty_q  <= wdata_i[4:0];
                end
                A_DISP:  disp_q <= wdata_i[1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer with reserved bits forced to zero.
    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            A_CLKSEL: rd_mux = {9'd0, div_q, 2'd0, src_q};
            A_CTRL:   rd_mux = {14'd0, dis_q, en_q};
            A_TIMING: rd_mux = {3'd0, frame_q, 3'd0, duty_q};
            A_DISP:   rd_mux = {14'd0, disp_q};
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, zero when no read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_en_i ? rd_mux : '0;
    end

    assign rdata_o = rdata_q;
    assign src_o   = src_q;
    assign div_o   = div_q;
    assign en_o    = en_q;
    assign dis_o   = dis_q;
    assign frame_o = frame_q;
    assign duty_o  = duty_q;
    assign disp_o  = disp_q;

    p_clksel_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(src_q) && $stable(div_q)));

    p_no_reserved_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q != DIV_RESERVED);

    p_disp_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> (disp_q == 2'd0));

endmodule

// File: rtl/lcd_clkctl_prescaler.sv
// Selects one of the source ticks and divides it by a power of two.
// Assumes the ticks are single-cycle strobes synchronous to clk. The counter
// is held at zero while disabled, so each enable starts a fresh period.
module lcd_clkctl_prescaler #(
    parameter int N_SRC = 4,
    parameter int CNT_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [N_SRC-1:0]         tick_i,
    input  logic [$clog2(N_SRC)-1:0] src_i,
    input  logic [2:0]               div_i,
    output logic                     clk_en_o
);

    logic             sel_tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             ce_q;

    assign sel_tick = tick_i[src_i];

    // Terminal count: code 0 passes every tick, code n divides by 2^(n+3).
    always_comb begin
        if (div_i == 3'd0) last = '0;
        else               last = CNT_W'((32'd1 << (32'(div_i) + 32'd3)) - 32'd1);
    end

    // Tick counter and output pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
            ce_q  <= 1'b0;
        end else if (sel_tick) begin
            if (cnt_q >= last) begin
                cnt_q <= '0;
                ce_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                ce_q  <= 1'b0;
            end
        end else begin
            ce_q <= 1'b0;
        end
    end

    assign clk_en_o = ce_q;

    p_ce_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !clk_en_o);

    p_ce_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> !clk_en_o);

endmodule

// File: rtl/lcd_clkctl_pinmode.sv
// Derives the SEG/COM pad mode from enable, discharge and display state.
// Purely combinational; clk and rst_n serve only the assertions.
module lcd_clkctl_pinmode
    import lcd_clkctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       dis_i,
    input  logic [1:0] disp_i,
    output logic [1:0] mode_o
);

    pin_mode_e mode;

    // Pad mode decision.
    always_comb begin
        if (!en_i)                mode = PIN_HIZ;
        else if (disp_i[1])       mode = PIN_NORMAL;
        else if (disp_i == 2'd1)  mode = dis_i ? PIN_LOW : PIN_HIZ;
        else                      mode = PIN_LOW;
    end

    assign mode_o = mode;

    p_hiz_when_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (mode_o == PIN_HIZ));

    p_normal_needs_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == PIN_NORMAL) |-> (en_i && disp_i[1]));

endmodule

// File: rtl/lcd_clkctl.sv
// Top level of the LCD clock and pin-enable controller.
// Assumes all source ticks are synchronous to clk.
module lcd_clkctl
    import lcd_clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clk_en_o,
    output logic [1:0]        pin_mode_o,
    output logic [4:0]        frame_cnt_o,
    output logic [4:0]        duty_o,
    output logic [1:0]        disp_ctl_o
);

    localparam int N_SRC = 4;
    localparam int CNT_W = 9;

    logic [1:0] src;
    logic [2:0] div;
    logic       en;
    logic       dis;

    lcd_clkctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .src_o   (src),
        .div_o   (div),
        .en_o    (en),
        .dis_o   (dis),
        .frame_o (frame_cnt_o),
        .duty_o  (duty_o),
        .disp_o  (disp_ctl_o)
    );

    lcd_clkctl_prescaler #(
        .N_SRC (N_SRC),
        .CNT_W (CNT_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .tick_i   (src_tick_i),
        .src_i    (src),
        .div_i    (div),
        .clk_en_o (clk_en_o)
    );

    lcd_clkctl_pinmode u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .dis_i  (dis),
        .disp_i (disp_ctl_o),
        .mode_o (pin_mode_o)
    );

endmodule

// File: tb/lcd_clkctl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module lcd_clkctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        clk_en;
    logic [1:0]  pin_mode;
    logic [4:0]  frame_cnt;
    logic [4:0]  duty;
    logic [1:0]  disp_ctl;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    lcd_clkctl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_tick_i  (src_tick),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .clk_en_o    (clk_en),
        .pin_mode_o  (pin_mode),
        .frame_cnt_o (frame_cnt),
        .duty_o      (duty),
        .disp_ctl_o  (disp_ctl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check(pin_mode == 2'b00, "R4 reset pins", pin_mode, 0);
        check(clk_en == 1'b0, "R9 reset ce", clk_en, 0);
        check(frame_cnt == 5'h01, "R7 reset frame", frame_cnt, 1);
        check(duty == 5'h1f, "R7 reset duty", duty, 'h1f);
        rd(8'h00, v); check(v == 16'h0000, "R2 reset clksel", v, 0);
        rd(8'h02, v); check(v == 16'h0000, "R4 reset ctrl", v, 0);
        rd(8'h04, v); check(v == 16'h011f, "R7 reset timing", v, 'h011f);
        rd(8'h06, v); check(v == 16'h0000, "R6 reset disp", v, 0);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        rd(8'h08, v); check(v == 16'h0000, "R8 unmapped 0x08", v, 0);
        rd(8'h01, v); check(v == 16'h0000, "R8 unmapped 0x01", v, 0);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(8'h04, 16'hffff);
        rd(8'h04, v); check(v == 16'h1f1f, "R7 reserved timing", v, 'h1f1f);
        check(frame_cnt == 5'h1f && duty == 5'h1f, "R7 outputs", {frame_cnt, duty}, 'h3ff);
        wr(8'h04, 16'h0a05);
        check(frame_cnt == 5'h0a && duty == 5'h05, "R7 outputs2", {frame_cnt, duty}, 'h145);
        wr(8'h02, 16'hfffe);
        rd(8'h02, v); check(v == 16'h0002, "R4 reserved ctrl", v, 2);
        check(pin_mode == 2'b00, "R4 pins disabled", pin_mode, 0);
        wr(8'h02, 16'h0000);
    endtask

    task automatic t_clksel();
        logic [15:0] v;
        wr(8'h00, 16'h0012);
        rd(8'h00, v); check(v == 16'h0012, "R2 clksel write", v, 'h12);
        wr(8'h00, 16'h0071);
        rd(8'h00, v); check(v == 16'h0011, "R2 code 7 kept", v, 'h11);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        wr(8'h02, 16'h0001);
        wr(8'h00, 16'h0033);
        rd(8'h00, v); check(v == 16'h0011, "R3 locked", v, 'h11);
        wr(8'h02, 16'h0000);
        wr(8'h00, 16'h0033);
        rd(8'h00, v); check(v == 16'h0033, "R3 unlocked", v, 'h33);
    endtask

    // Selected source ticks every third cycle; the others tick every cycle.
    task automatic t_divide(input int src, input int code, input int nticks,
                            input int exp_pulses, input int exp_first, input string req);
        int ticks = 0;
        int pulses = 0;
        int first = 0;
        wr(8'h02, 16'h0000);
        wr(8'h00, 16'((code << 4) | src));
        wr(8'h02, 16'h0001);
        for (int c = 0; ticks < nticks; c++) begin
            logic [3:0] t;
            t = ~(4'b0001 << src);
            if (c % 3 == 0) begin
                t[src] = 1'b1;
                ticks++;
            end
            src_tick = t;
            @(negedge clk);
            if (clk_en) begin
                pulses++;
                if (first == 0) first = ticks;
            end
        end
        src_tick = '0;
        @(negedge clk);
        if (clk_en) pulses++;
        check(pulses == exp_pulses, req, pulses, exp_pulses);
        check(first == exp_first, "R9 first pulse", first, exp_first);
    endtask

    task automatic t_disabled_quiet();
        int seen = 0;
        wr(8'h02, 16'h0000);
        for (int c = 0; c < 40; c++) begin
            src_tick = 4'hf;
            @(negedge clk);
            if (clk_en) seen++;
        end
        src_tick = '0;
        check(seen == 0, "R9 quiet when disabled", seen, 0);
    endtask

    task automatic t_pins();
        logic [15:0] v;
        wr(8'h06, 16'h0002);
        check(pin_mode == 2'b00, "R4 disabled disp on", pin_mode, 0);
        wr(8'h06, 16'h0000);
        wr(8'h02, 16'h0001);
        check(pin_mode == 2'b01, "R5 idle low", pin_mode, 1);
        wr(8'h06, 16'h0001);
        check(pin_mode == 2'b00, "R5 off no discharge", pin_mode, 0);
        wr(8'h02, 16'h0003);
        check(pin_mode == 2'b01, "R5 off discharge", pin_mode, 1);
        wr(8'h06, 16'h0002);
        check(pin_mode == 2'b10, "R5 on code 2", pin_mode, 2);
        wr(8'h06, 16'h0003);
        check(pin_mode == 2'b10, "R5 on code 3", pin_mode, 2);
        wr(8'h02, 16'h0002);
        check(disp_ctl == 2'd0, "R6 disp cleared", disp_ctl, 0);
        check(pin_mode == 2'b00, "R4 pins after disable", pin_mode, 0);
        rd(8'h06, v); check(v == 16'h0000, "R6 disp readback", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_reserved();
        t_clksel();
        t_lock();
        t_divide(0, 0, 10, 10, 1, "R1 R2 src0 div1");
        t_divide(1, 1, 48, 3, 16, "R1 R2 src1 div16");
        t_divide(2, 2, 64, 2, 32, "R1 R2 src2 div32");
        t_divide(3, 6, 1024, 2, 512, "R1 R2 src3 div512");
        t_disabled_quiet();
        t_pins();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule